// File: doc/BRIEF.md
# Soft-Decision Depuncturer

This block sits between a demodulator and a K=7 Viterbi decoder. The demodulator delivers one pair of 3-bit soft values (I and Q) per symbol. The transmitter built a rate-1/2 mother code and then dropped some of its coded bits according to a fixed periodic keep/delete pattern. This block walks the same pattern, one column per decoded bit. For every column it hands the decoder a full (G1, G2) soft pair. Where a bit was dropped, the block puts in a neutral mid-scale value and raises an erasure flag for that branch.

Five code rates are supported: 1/2, 2/3, 3/4, 5/6 and 7/8. One input symbol carries two soft values, while one output column consumes one or two of them. For that reason the block keeps a small buffer of pending soft values and throttles the demodulator with a ready signal. Over a full pattern period, the output column rate relative to the input symbol rate is 1, 4/3, 3/2, 5/3 and 7/4 respectively.

The code rate and the starting column of the pattern are static inputs. They are taken into account by a synchronous reset. An outer synchronisation loop can therefore try another rate or phase by pulsing reset.

Top module: `dp_depuncture`

## Requirements
- R1: `rate_sel_i` selects the pattern. 0 is rate 1/2 with period 1, G1 kept and G2 kept. 1 is rate 2/3 with period 2, G1 kept in columns 0 only and G2 in columns 0,1. 2 is rate 3/4 with period 3, G1 kept in columns 0,2 and G2 in columns 0,1. 3 is rate 5/6 with period 5, G1 kept in columns 0,2,4 and G2 in columns 0,1,3. 4 is rate 7/8 with period 7, G1 kept in columns 0,4,6 and G2 in columns 0,1,2,3,5.
- R2: Kept soft values are used in arrival order. Within a symbol, I comes before Q. Within a column, the G1 value is taken before the G2 value. A kept branch outputs its soft value unchanged.
- R3: A deleted branch outputs the neutral value 3'b100 with its erasure flag at 1. A kept branch has its erasure flag at 0.
- R4: Exactly one output pair (`br_valid_o` high for one cycle) is produced per pattern column, in column order. No pair is produced while the buffer holds fewer soft values than the current column needs.
- R5: `sym_ready_o` is low only when the buffer cannot take two more soft values in the current cycle. A symbol offered while ready is high is never lost. Ready is never low for two cycles in a row.
- R6: While `rst` is high, the output valid goes to 0, the buffer empties and `sym_ready_o` is 1. The column counter loads `phase_i` when it is less than the period, and loads 0 otherwise.
- R7: The two erasure flags of an output pair are never both 1.
- R8: `rate_sel_i` codes 5, 6 and 7 behave exactly as rate 1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads rate and phase |
| rate_sel_i | input | 3 | Code rate select, held stable outside reset |
| phase_i | input | 3 | Starting pattern column, sampled during reset |
| sym_valid_i | input | 1 | Input symbol offered |
| sym_i_i | input | 3 | I soft value, offset binary (0 strong zero, 7 strong one) |
| sym_q_i | input | 3 | Q soft value, offset binary |
| sym_ready_o | output | 1 | Block accepts the offered symbol this cycle |
| br_valid_o | output | 1 | Output pair valid |
| br_g1_o | output | 3 | First generator branch soft value |
| br_g2_o | output | 3 | Second generator branch soft value |
| br_era1_o | output | 1 | First branch was erased |
| br_era2_o | output | 1 | Second branch was erased |

## Verification
The properties assume two things about the inputs. First, `rate_sel_i` and `phase_i` change only while `rst` is high. Second, the decoder side always accepts a pair. Neither output has a back-pressure path. The bench sets rate and phase inside a reset window before every run and never changes them mid-stream. Each run is a whole number of double pattern periods, so that no odd soft value is left in the buffer. Random idle gaps on the symbol side vary the buffer fill, and gap-free runs at rate 7/8 force the ready signal low.

// File: rtl/dp_pkg.sv
package dp_pkg;
    parameter int SOFT_W     = 3;
    parameter int MAX_PERIOD = 7;
    parameter int RATE_W     = 3;

    localparam int COL_W  = $clog2(MAX_PERIOD);
    localparam int MASK_W = 1 << COL_W;

    typedef logic [SOFT_W-1:0] soft_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [RATE_W-1:0] rsel_t;

    // Mid-scale soft value: no preference for 0 or 1.
    localparam soft_t NEUTRAL = soft_t'(1 << (SOFT_W - 1));

    typedef enum logic [RATE_W-1:0] {
        RATE_1_2 = 3'd0,
        RATE_2_3 = 3'd1,
        RATE_3_4 = 3'd2,
        RATE_5_6 = 3'd3,
        RATE_7_8 = 3'd4
    } rate_e;

    typedef struct packed {
        logic keep_x;
        logic keep_y;
    } keep_t;

    typedef struct packed {
        soft_t g1;
        soft_t g2;
        logic  era1;
        logic  era2;
    } branch_t;

    function automatic col_t period_of(rsel_t r);
        case (r)
            RATE_2_3: return col_t'(2);
            RATE_3_4: return col_t'(3);
            RATE_5_6: return col_t'(5);
            RATE_7_8: return col_t'(7);
            default:  return col_t'(1);
        endcase
    endfunction

    // Bit c of a mask stands for pattern column c.
    function automatic mask_t x_mask(rsel_t r);
        case (r)
            RATE_2_3: return mask_t'(8'b0000_0001);
            RATE_3_4: return mask_t'(8'b0000_0101);
            RATE_5_6: return mask_t'(8'b0001_0101);
            RATE_7_8: return mask_t'(8'b0101_0001);
            default:  return mask_t'(8'b0000_0001);
        endcase
    endfunction

    function automatic mask_t y_mask(rsel_t r);
        case (r)
            RATE_2_3: return mask_t'(8'b0000_0011);
            RATE_3_4: return mask_t'(8'b0000_0011);
            RATE_5_6: return mask_t'(8'b0000_1011);
            RATE_7_8: return mask_t'(8'b0010_1111);
            default:  return mask_t'(8'b0000_0001);
        endcase
    endfunction
endpackage

// File: rtl/dp_map.sv
module dp_map
    import dp_pkg::*;
(
    input  rsel_t      rate_i,
    input  col_t       col_i,
    output keep_t      keep_o,
    output col_t       period_o,
    output logic [1:0] need_o
);
    mask_t xm;
    mask_t ym;

    always_comb begin
        xm            = x_mask(rate_i);
        ym            = y_mask(rate_i);
        keep_o.keep_x = xm[col_i];
        keep_o.keep_y = ym[col_i];
        period_o      = period_of(rate_i);
        need_o        = {1'b0, keep_o.keep_x} + {1'b0, keep_o.keep_y};
    end
endmodule

// File: rtl/dp_col_ctr.sv
module dp_col_ctr
    import dp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  col_t phase_i,
    input  col_t period_i,
    input  logic adv_i,
    output col_t col_o
);
    col_t col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= (phase_i < period_i) ? phase_i : '0;
        end else if (adv_i) begin
            col_q <= (col_q == period_i - col_t'(1)) ? '0 : col_q + col_t'(1);
        end
    end

    assign col_o = col_q;
endmodule

// File: rtl/dp_softq.sv
module dp_softq
    import dp_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  soft_t            push_d0_i,
    input  soft_t            push_d1_i,
    input  logic [1:0]       pop_n_i,
    output logic [CNT_W-1:0] cnt_o,
    output soft_t            head0_o,
    output soft_t            head1_o
);
    soft_t            q_q [DEPTH];
    soft_t            q_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] after_pop;

    always_comb begin
        after_pop = cnt_q - CNT_W'(pop_n_i);
        cnt_d     = after_pop;
        for (int k = 0; k < DEPTH; k++) begin
            q_d[k] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j == k + int'(pop_n_i)) q_d[k] = q_q[j];
            end
        end
        if (push_i) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (k == int'(after_pop))     q_d[k] = push_d0_i;
                if (k == int'(after_pop) + 1) q_d[k] = push_d1_i;
            end
            cnt_d = after_pop + CNT_W'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int k = 0; k < DEPTH; k++) q_q[k] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int k = 0; k < DEPTH; k++) q_q[k] <= q_d[k];
        end
    end

    assign cnt_o   = cnt_q;
    assign head0_o = q_q[0];
    assign head1_o = q_q[1];
endmodule

// File: rtl/dp_depuncture.sv
module dp_depuncture
    import dp_pkg::*;
#(
    parameter int QDEPTH = 3,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic [COL_W-1:0]  phase_i,
    input  logic              sym_valid_i,
    input  logic [SOFT_W-1:0] sym_i_i,
    input  logic [SOFT_W-1:0] sym_q_i,
    output logic              sym_ready_o,
    output logic              br_valid_o,
    output logic [SOFT_W-1:0] br_g1_o,
    output logic [SOFT_W-1:0] br_g2_o,
    output logic              br_era1_o,
    output logic              br_era2_o
);
    col_t             col;
    col_t             period;
    keep_t            keep;
    logic [1:0]       need;
    logic [1:0]       pop_n;
    logic [CNT_W-1:0] fill;
    soft_t            head0;
    soft_t            head1;
    logic             fire;
    logic             push;
    branch_t          br_d;
    branch_t          br_q;
    logic             valid_q;

    dp_map u_map (
        .rate_i   (rate_sel_i),
        .col_i    (col),
        .keep_o   (keep),
        .period_o (period),
        .need_o   (need)
    );

    dp_col_ctr u_col (
        .clk      (clk),
        .rst      (rst),
        .phase_i  (phase_i),
        .period_i (period),
        .adv_i    (fire),
        .col_o    (col)
    );

    dp_softq #(.DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push),
        .push_d0_i (sym_i_i),
        .push_d1_i (sym_q_i),
        .pop_n_i   (pop_n),
        .cnt_o     (fill),
        .head0_o   (head0),
        .head1_o   (head1)
    );

    always_comb begin
        fire        = int'(fill) >= int'(need);
        pop_n       = fire ? need : 2'd0;
        sym_ready_o = (int'(fill) - int'(pop_n)) <= (QDEPTH - 2);
        push        = sym_valid_i && sym_ready_o;

        br_d.g1   = keep.keep_x ? head0 : NEUTRAL;
        br_d.g2   = keep.keep_y ? (keep.keep_x ? head1 : head0) : NEUTRAL;
        br_d.era1 = !keep.keep_x;
        br_d.era2 = !keep.keep_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            br_q    <= '0;
        end else begin
            valid_q <= fire;
            if (fire) br_q <= br_d;
        end
    end

    assign br_valid_o = valid_q;
    assign br_g1_o    = br_q.g1;
    assign br_g2_o    = br_q.g2;
    assign br_era1_o  = br_q.era1;
    assign br_era2_o  = br_q.era2;
endmodule

// File: rtl/dp_depuncture_chk.sv
module dp_depuncture_chk
    import dp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [RATE_W-1:0] rate_sel_i,
    input logic              sym_ready_o,
    input logic              br_valid_o,
    input logic [SOFT_W-1:0] br_g1_o,
    input logic [SOFT_W-1:0] br_g2_o,
    input logic              br_era1_o,
    input logic              br_era2_o
);
    // R3
    erased_g1_neutral_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid_o && br_era1_o |-> br_g1_o == NEUTRAL);

    // R3
    erased_g2_neutral_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid_o && br_era2_o |-> br_g2_o == NEUTRAL);

    // R7
    one_erasure_max_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid_o |-> !(br_era1_o && br_era2_o));

    // R1 R8
    half_rate_unerased_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid_o && (rate_sel_i == 3'd0 || rate_sel_i > 3'd4) |-> !br_era1_o && !br_era2_o);

    // R1
    two_thirds_g2_kept_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid_o && rate_sel_i == 3'd1 |-> !br_era2_o);

    // R6
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !br_valid_o && sym_ready_o);

    // R5
    ready_recovers_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_ready_o |=> sym_ready_o);
endmodule

bind dp_depuncture dp_depuncture_chk u_chk (.*);

// File: tb/tb_dp_depuncture.sv
module tb_dp_depuncture;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] rate_sel = 3'd0;
    logic [2:0] phase = 3'd0;
    logic       sv = 1'b0;
    logic [2:0] si = 3'd0;
    logic [2:0] sq = 3'd0;
    logic       sym_ready_o, br_valid_o, br_era1_o, br_era2_o;
    logic [2:0] br_g1_o, br_g2_o;

    always #10 clk = ~clk;

    dp_depuncture dut (
        .clk(clk), .rst(rst), .rate_sel_i(rate_sel), .phase_i(phase),
        .sym_valid_i(sv), .sym_i_i(si), .sym_q_i(sq), .sym_ready_o(sym_ready_o),
        .br_valid_o(br_valid_o), .br_g1_o(br_g1_o), .br_g2_o(br_g2_o),
        .br_era1_o(br_era1_o), .br_era2_o(br_era2_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    logic [2:0] tx[$];
    logic [7:0] ex[$];

    function automatic string gpat(int r, bit second);
        case (r)
            1: return second ? "11"      : "10";
            2: return second ? "110"     : "101";
            3: return second ? "11010"   : "10101";
            4: return second ? "1111010" : "1000101";
            default: return "1";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL R4 watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    task automatic run_case(int r, int ph, int gap, bit want_stall, string tag);
        string xp = gpat(r, 1'b0);
        string yp = gpat(r, 1'b1);
        int per   = xp.len();
        int st    = (ph < per) ? ph : 0;
        int ncols = 16 * per;
        int got   = 0;
        bit stall = 1'b0;
        tx.delete();
        ex.delete();
        for (int k = 0; k < ncols; k++) begin
            int c = (st + k) % per;
            bit kx = (xp.getc(c) == 8'd49);
            bit ky = (yp.getc(c) == 8'd49);
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [2:0] b = 3'($urandom_range(0, 7));
            if (kx) tx.push_back(a);
            if (ky) tx.push_back(b);
            ex.push_back({kx ? a : 3'b100, ky ? b : 3'b100, !kx, !ky});
        end
        @(negedge clk);
        rst = 1'b1;
        sv = 1'b0;
        rate_sel = 3'(r);
        phase = 3'(ph);
        repeat (2) @(negedge clk);
        check(sym_ready_o == 1'b1 && br_valid_o == 1'b0, "R6", "reset state",
              {sym_ready_o, br_valid_o}, 2'b10);
        rst = 1'b0;
        fork
            begin : drive
                int p = 0;
                int npairs = tx.size() / 2;
                while (p < npairs) begin
                    @(negedge clk);
                    if (gap > 0 && $urandom_range(0, 99) < gap) sv = 1'b0;
                    else begin
                        sv = 1'b1;
                        si = tx[2*p];
                        sq = tx[2*p+1];
                    end
                    if (sv && sym_ready_o) p++;
                    else if (sv) stall = 1'b1;
                end
                @(negedge clk);
                sv = 1'b0;
            end
            begin : watch
                int w = 0;
                while (got < ncols && w < 4000) begin
                    @(negedge clk);
                    w++;
                    if (br_valid_o) begin
                        logic [7:0] act = {br_g1_o, br_g2_o, br_era1_o, br_era2_o};
                        string req = (tag != "") ? tag : ((ex[got][1] | ex[got][0]) ? "R3" : "R2");
                        check(act == ex[got], req, $sformatf("R1 rate %0d column pair %0d", r, got),
                              act, ex[got]);
                        got++;
                    end
                end
            end
        join
        check(got == ncols, "R4", "pair count", got, ncols);
        repeat (6) begin
            @(negedge clk);
            check(br_valid_o == 1'b0, "R4", "idle without data", br_valid_o, 0);
        end
        if (want_stall) check(stall, "R5", "ready dropped at full input rate", stall, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_case(0, 0, 30, 1'b0, "");
        run_case(1, 1, 30, 1'b0, "");
        run_case(2, 2, 0,  1'b0, "");
        run_case(3, 4, 20, 1'b0, "");
        run_case(4, 3, 0,  1'b1, "R5");
        run_case(4, 0, 40, 1'b0, "");
        run_case(1, 5, 25, 1'b0, "R6");
        run_case(2, 7, 0,  1'b0, "R6");
        run_case(6, 0, 10, 1'b0, "R8");
        run_case(5, 3, 0,  1'b0, "R8");
        for (int n = 0; n < 8; n++) begin
            int r = $urandom_range(0, 4);
            int ph = $urandom_range(0, gpat(r, 1'b0).len() - 1);
            run_case(r, ph, $urandom_range(0, 60), 1'b0, "");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule